// File: doc/BRIEF.md
# UART Receive FIFO with Per-Entry Error Tags

This block is the receive-side character store of a 16550-class serial port. A bit-level deserializer hands it one assembled character at a time, together with that character's parity and framing error indications. A separate level input reports that the line is being held in the break state. Each accepted character is written into a FIFO as a word made of the character and a small error tag. The character is trimmed to the programmed character length before it is stored.

The error tag of an entry does not reach the host's line-status flags when the character arrives. It is merged into the sticky status flags only when that entry becomes the oldest one in the FIFO. The tag is then wiped from the entry, so each error is reported once, next to the character it belongs to. The block also keeps the data-ready and overrun flags. It turns a long break into a zero character with its own tag, obeys a receive-FIFO flush command, and runs the character-timeout counter that an interrupt block would use. The host reads the oldest character, pops it with a strobe, and clears the sticky flags with a status-read strobe.

Top module: `uart_rx_tagfifo`

## Requirements
- R1: With `fifo_en` high the FIFO holds up to DEPTH (default 16) characters. With `fifo_en` low it holds exactly one, and `level` never exceeds that capacity.
- R2: A stored character keeps only its low `char_len_sel`+5 bits and the rest are zero. The encodings 0, 1, 2, 3 give 5, 6, 7 and 8 bits.
- R3: A character that arrives while `level` equals the capacity is discarded and the stored contents are unchanged. `overrun` and `err_sum` are both set on the next clock.
- R4: Every arrival, including a discarded one, sets `data_ready` and clears `timeout_cnt` on the next clock.
- R5: An entry's error tag sets `parity_err`, `frame_err` and `err_sum` only once the entry is the oldest in the FIFO, one clock after it gets there. After a status read has cleared them, the same entry does not set them again.
- R6: A break is declared on the character tick that follows BRK_CHARS (default 4) ticks with `line_brk` held high. A new break is declared only after `line_brk` has gone low.
- R7: A declared break stores the character 0x00. When that entry is oldest, it sets `brk_flag`, `frame_err` and `err_sum`, and also `parity_err` if `parity_en` is high.
- R8: `rx_flush` empties the FIFO and clears `data_ready` on the next clock. A character arriving in the same cycle is dropped. The flush does not persist, so the next arrival is stored.
- R9: `timeout_cnt` increases by one on each `char_tick` while `data_ready` is high and holds at its all-ones value. It does not change on ticks while `data_ready` is low.
- R10: `rd_data` shows the oldest character. `rd_pop` removes it, and `data_ready` falls when the last one is removed. A pop on an empty FIFO has no effect.
- R11: `rd_status` clears `overrun`, `brk_flag`, `frame_err`, `parity_err` and `err_sum`.
- R12: Characters leave in arrival order, including after the storage pointers wrap around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects the deep FIFO, 0 a single-entry holding register |
| rx_flush | input | 1 | One-cycle receive-FIFO flush command |
| char_len_sel | input | 2 | Character length: 0..3 give 5..8 bits |
| parity_en | input | 1 | Parity enabled in the line setup |
| rx_valid | input | 1 | A character is presented this cycle |
| rx_char | input | 8 | Received character |
| rx_perr | input | 1 | Parity error for `rx_char` |
| rx_ferr | input | 1 | Framing error for `rx_char` |
| line_brk | input | 1 | Receive line currently held in break |
| char_tick | input | 1 | One-cycle pulse once per character time |
| rd_pop | input | 1 | Host reads (pops) the oldest character |
| rd_data | output | 8 | Oldest character |
| rd_status | input | 1 | Host reads line status; clears sticky flags |
| data_ready | output | 1 | At least one character is available |
| overrun | output | 1 | A character was lost to a full FIFO |
| brk_flag | output | 1 | Break reported |
| frame_err | output | 1 | Framing error reported |
| parity_err | output | 1 | Parity error reported |
| err_sum | output | 1 | Any receive error reported |
| timeout_cnt | output | TMO_W | Character times elapsed with data waiting |
| level | output | clog2(DEPTH+1) | Number of stored characters |

## Verification
The properties assume that `fifo_en` changes only while the FIFO is empty, since a capacity change with entries present makes the level bound meaningless. They also assume that `rx_flush`, `rd_pop`, `rd_status` and `char_tick` are single-cycle strobes driven between clock edges. The stimulus changes the depth mode only right after a flush and holds every strobe for exactly one cycle. It asserts `line_brk` only when the FIFO is empty, so the break character's arrival and tag timing can be predicted.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   localparam int CHAR_W = 8;

   // Error tag carried by each stored character
   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
      logic esum;
   } rxq_tag_t;

   localparam int TAG_W = $bits(rxq_tag_t);

   typedef struct packed {
      rxq_tag_t              tag;
      logic [CHAR_W-1:0]     ch;
   } rxq_entry_t;

   // Keeps sel+5 low bits of a character
   function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] sel);
      return {CHAR_W{1'b1}} >> (2'd3 - sel);
   endfunction

endpackage

// File: rtl/rxq_break_det.sv
module rxq_break_det #(
   parameter int BRK_CHARS = 4,
   localparam int BW = $clog2(BRK_CHARS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_brk,
   input  logic char_tick,
   output logic fire
);

   logic [BW-1:0] held_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
         done_q <= 1'b0;
         fire   <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!line_brk) begin
            held_q <= '0;
            done_q <= 1'b0;
         end else if (char_tick) begin
            if (held_q == BW'(BRK_CHARS)) begin
               if (!done_q) begin
                  fire   <= 1'b1;
                  done_q <= 1'b1;
               end
            end else begin
               held_q <= held_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
   parameter int TMO_W    = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             enable,
   output logic [TMO_W-1:0] cnt
);

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            cnt <= '0;
         else if (clear)                        cnt <= '0;
         else if (tick && enable && cnt != '1)  cnt <= cnt + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt <= '0;
         else if (clear)           cnt <= '0;
         else if (tick && enable)  cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       wide,
   input  logic       push,
   input  rxq_entry_t push_word,
   input  logic       pop,
   output rxq_entry_t head_word,
   output rxq_tag_t   tag_out,
   output logic       full,
   output logic [LW-1:0] level
);

   logic [PW-1:0] wr_ptr, rd_ptr, lim, wr_nxt, rd_nxt;
   logic [LW-1:0] cap;
   logic          push_ok, pop_ok, take;
   rxq_entry_t    mem [DEPTH];

   always_comb begin
      lim     = wide ? PW'(DEPTH - 1) : '0;
      cap     = wide ? LW'(DEPTH) : LW'(1);
      full    = (level >= cap);
      push_ok = push && !full && !flush;
      pop_ok  = pop && (level != '0) && !flush;
      take    = (level != '0) && !flush;
      wr_nxt  = (wr_ptr >= lim) ? '0 : wr_ptr + 1'b1;
      rd_nxt  = (rd_ptr >= lim) ? '0 : rd_ptr + 1'b1;
   end

   assign head_word = mem[rd_ptr];
   assign tag_out   = take ? mem[rd_ptr].tag : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         level <= level + LW'(push_ok) - LW'(pop_ok);
      end
   end

   // One slot per entry: written on push, tag wiped once it is merged
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rxq_entry_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (push_ok && wr_ptr == PW'(i))
            slot_q <= push_word;
         else if (take && rd_ptr == PW'(i))
            slot_q.tag <= '0;
      end
      assign mem[i] = slot_q;
   end

endmodule

// File: rtl/uart_rx_tagfifo.sv
module uart_rx_tagfifo
   import rxq_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int BRK_CHARS = 4,
   parameter int TMO_W     = 6,
   parameter bit TMO_SAT   = 1'b1,
   localparam int LVL_W    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic             rx_flush,
   input  logic [1:0]       char_len_sel,
   input  logic             parity_en,
   input  logic             rx_valid,
   input  logic [7:0]       rx_char,
   input  logic             rx_perr,
   input  logic             rx_ferr,
   input  logic             line_brk,
   input  logic             char_tick,
   input  logic             rd_pop,
   output logic [7:0]       rd_data,
   input  logic             rd_status,
   output logic             data_ready,
   output logic             overrun,
   output logic             brk_flag,
   output logic             frame_err,
   output logic             parity_err,
   output logic             err_sum,
   output logic [TMO_W-1:0] timeout_cnt,
   output logic [LVL_W-1:0] level
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BRK_CHARS < 1) begin : g_bad_brk
      $error("BRK_CHARS must be at least 1");
   end
   if (TMO_W < 2) begin : g_bad_tmo
      $error("TMO_W must be at least 2");
   end

   logic       brk_fire, arrive, overflow, popping, full;
   rxq_entry_t push_word, head_word;
   rxq_tag_t   merge_tag;

   rxq_break_det #(.BRK_CHARS(BRK_CHARS)) u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_brk (line_brk),
      .char_tick(char_tick),
      .fire     (brk_fire)
   );

   // A declared break takes the slot of any coincident character
   always_comb begin
      if (brk_fire) begin
         push_word.ch  = '0;
         push_word.tag = '{brk: 1'b1, ferr: 1'b1, perr: parity_en, esum: 1'b1};
      end else begin
         push_word.ch  = rx_char & len_mask(char_len_sel);
         push_word.tag = '{brk: 1'b0, ferr: rx_ferr, perr: rx_perr,
                           esum: rx_ferr | rx_perr};
      end
   end

   assign arrive   = (rx_valid || brk_fire) && !rx_flush;
   assign overflow = arrive && full;
   assign popping  = rd_pop && (level != '0) && !rx_flush;

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (rx_flush),
      .wide     (fifo_en),
      .push     (arrive),
      .push_word(push_word),
      .pop      (rd_pop),
      .head_word(head_word),
      .tag_out  (merge_tag),
      .full     (full),
      .level    (level)
   );

   assign rd_data = head_word.ch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_ready <= 1'b0;
         overrun    <= 1'b0;
         brk_flag   <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
         err_sum    <= 1'b0;
      end else begin
         if (rx_flush)                            data_ready <= 1'b0;
         else if (arrive)                         data_ready <= 1'b1;
         else if (popping && level == LVL_W'(1))  data_ready <= 1'b0;

         overrun    <= (overrun    && !rd_status) || overflow;
         brk_flag   <= (brk_flag   && !rd_status) || merge_tag.brk;
         frame_err  <= (frame_err  && !rd_status) || merge_tag.ferr;
         parity_err <= (parity_err && !rd_status) || merge_tag.perr;
         err_sum    <= (err_sum    && !rd_status) || merge_tag.esum || overflow;
      end
   end

   rxq_timeout #(.TMO_W(TMO_W), .SATURATE(TMO_SAT)) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (arrive),
      .tick  (char_tick),
      .enable(data_ready),
      .cnt   (timeout_cnt)
   );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DEPTH = 16,
   parameter int TMO_W = 6,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fifo_en,
   input logic             rx_flush,
   input logic             rx_valid,
   input logic             rd_pop,
   input logic             rd_status,
   input logic             char_tick,
   input logic             line_brk,
   input logic             brk_fire,
   input logic [LVL_W-1:0] level,
   input logic             data_ready,
   input logic             overrun,
   input logic             err_sum,
   input logic [TMO_W-1:0] timeout_cnt
);

   logic [LVL_W-1:0] cap;
   assign cap = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);

   p_depth_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && level <= LVL_W'(1)) |=> (fifo_en || level <= LVL_W'(1)));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_flush && !rd_pop && level == cap)
      |=> (overrun && err_sum && level == $past(level)));

   p_arrival_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_flush) |=> (data_ready && timeout_cnt == '0));

   p_brk_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_fire |-> $past(line_brk));

   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (level == '0 && !data_ready));

   p_tmo_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (char_tick && data_ready && !rx_valid && !brk_fire && timeout_cnt != '1)
      |=> timeout_cnt == TMO_W'($past(timeout_cnt) + 1'b1));

   p_ready_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready == (level != '0));

   p_status_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && level == '0) |=> !overrun);

endmodule

bind uart_rx_tagfifo rxq_checker #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_en    (fifo_en),
   .rx_flush   (rx_flush),
   .rx_valid   (rx_valid),
   .rd_pop     (rd_pop),
   .rd_status  (rd_status),
   .char_tick  (char_tick),
   .line_brk   (line_brk),
   .brk_fire   (brk_fire),
   .level      (level),
   .data_ready (data_ready),
   .overrun    (overrun),
   .err_sum    (err_sum),
   .timeout_cnt(timeout_cnt)
);

// File: tb/sim_uart_rx_tagfifo.sv
`timescale 1ns/1ps
module sim_uart_rx_tagfifo;

   localparam int DEPTH = 16;
   localparam int BRKC  = 4;
   localparam int TMO_W = 6;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_en = 1'b1, rx_flush = 1'b0, parity_en = 1'b0;
   logic [1:0] char_len_sel = 2'd3;
   logic rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
   logic [7:0] rx_char = '0;
   logic line_brk = 1'b0, char_tick = 1'b0, rd_pop = 1'b0, rd_status = 1'b0;
   logic [7:0] rd_data;
   logic data_ready, overrun, brk_flag, frame_err, parity_err, err_sum;
   logic [TMO_W-1:0] timeout_cnt;
   logic [LVL_W-1:0] level;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   logic [7:0] exp_q [$];

   always #10 clk = ~clk;

   uart_rx_tagfifo #(.DEPTH(DEPTH), .BRK_CHARS(BRKC), .TMO_W(TMO_W)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_flush(rx_flush),
      .char_len_sel(char_len_sel), .parity_en(parity_en), .rx_valid(rx_valid),
      .rx_char(rx_char), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
      .line_brk(line_brk), .char_tick(char_tick), .rd_pop(rd_pop),
      .rd_data(rd_data), .rd_status(rd_status), .data_ready(data_ready),
      .overrun(overrun), .brk_flag(brk_flag), .frame_err(frame_err),
      .parity_err(parity_err), .err_sum(err_sum), .timeout_cnt(timeout_cnt),
      .level(level)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: presents one character, records the expected stored byte
   task automatic send(input logic [7:0] ch, input logic pe, input logic fe);
      int cap;
      cap = fifo_en ? DEPTH : 1;
      rx_char = ch; rx_perr = pe; rx_ferr = fe; rx_valid = 1'b1;
      if (exp_q.size() < cap)
         exp_q.push_back(ch & (8'hFF >> (3 - int'(char_len_sel))));
      cyc(1);
      rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
   endtask

   // Monitor: compares the oldest character with the scoreboard, then pops
   task automatic pop_chk(input string req);
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(req, rd_data, e);
      rd_pop = 1'b1;
      cyc(1);
      rd_pop = 1'b0;
   endtask

   task automatic status_rd();
      rd_status = 1'b1; cyc(1); rd_status = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         char_tick = 1'b1; cyc(1); char_tick = 1'b0;
      end
   endtask

   task automatic flush();
      rx_flush = 1'b1; cyc(1); rx_flush = 1'b0;
      exp_q.delete();
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         report();
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // reset state (R10, R11)
      chk("R10 reset level", level, 0);
      chk("R10 reset data_ready", data_ready, 0);
      chk("R11 reset overrun", overrun, 0);
      chk("R11 reset err_sum", err_sum, 0);
      chk("R9 reset timeout", timeout_cnt, 0);

      // R2 length masking, R4 data_ready, R10 pop and empty
      char_len_sel = 2'd3; send(8'hA5, 0, 0);
      char_len_sel = 2'd0; send(8'hFF, 0, 0);
      char_len_sel = 2'd1; send(8'hC3, 0, 0);
      char_len_sel = 2'd2; send(8'hFF, 0, 0);
      char_len_sel = 2'd3;
      chk("R4 data_ready after arrival", data_ready, 1);
      chk("R1 level four", level, 4);
      pop_chk("R2 8-bit char");
      pop_chk("R2 5-bit char");
      pop_chk("R2 6-bit char");
      pop_chk("R2 7-bit char");
      chk("R10 data_ready after last pop", data_ready, 0);
      rd_pop = 1'b1; cyc(1); rd_pop = 1'b0;
      chk("R10 pop on empty level", level, 0);
      chk("R10 pop on empty data_ready", data_ready, 0);

      // R1 depth, R3 overrun, R4 timeout clear, R11 status read
      for (int i = 0; i < DEPTH; i++) send(8'(i * 7 + 1), 0, 0);
      chk("R1 full depth", level, DEPTH);
      ticks(3);
      chk("R9 timeout counts", timeout_cnt, 3);
      send(8'hEE, 0, 0);
      chk("R3 level unchanged", level, DEPTH);
      chk("R3 overrun", overrun, 1);
      chk("R3 err_sum", err_sum, 1);
      chk("R4 data_ready on overflow", data_ready, 1);
      chk("R4 timeout cleared on overflow", timeout_cnt, 0);
      status_rd();
      chk("R11 overrun cleared", overrun, 0);
      chk("R11 err_sum cleared", err_sum, 0);
      for (int i = 0; i < DEPTH; i++) pop_chk("R3 contents kept");

      // R12 order across pointer wrap
      for (int i = 0; i < 5; i++) send(8'(8'h40 + i), 0, 0);
      pop_chk("R12 order"); pop_chk("R12 order");
      for (int i = 0; i < 12; i++) send(8'(8'h80 + i), 0, 0);
      chk("R12 level after wrap", level, 15);
      while (exp_q.size() > 0) pop_chk("R12 wrapped order");

      // R9 timeout saturation and hold while empty
      send(8'h5A, 0, 0);
      ticks(70);
      chk("R9 timeout saturates", timeout_cnt, 63);
      flush();
      ticks(2);
      chk("R9 no count while empty", timeout_cnt, 63);

      // R5 tags merge only at the head, once
      send(8'h11, 0, 0);
      send(8'h22, 1, 0);
      cyc(3);
      chk("R5 parity not early", parity_err, 0);
      chk("R5 err_sum not early", err_sum, 0);
      pop_chk("R5 clean char");
      cyc(1);
      chk("R5 parity at head", parity_err, 1);
      chk("R5 err_sum at head", err_sum, 1);
      chk("R5 frame stays clear", frame_err, 0);
      status_rd();
      cyc(3);
      chk("R5 parity reported once", parity_err, 0);
      pop_chk("R5 tagged char data");
      send(8'h33, 0, 1);
      cyc(1);
      chk("R5 frame on empty arrival", frame_err, 1);
      pop_chk("R5 framing char data");
      status_rd();

      // R8 flush
      send(8'h01, 0, 0); send(8'h02, 0, 0); send(8'h03, 0, 0);
      flush();
      chk("R8 flush level", level, 0);
      chk("R8 flush data_ready", data_ready, 0);
      rx_flush = 1'b1; rx_valid = 1'b1; rx_char = 8'h44;
      cyc(1);
      rx_flush = 1'b0; rx_valid = 1'b0;
      chk("R8 arrival during flush dropped", level, 0);
      send(8'h55, 0, 0);
      chk("R8 next arrival stored", level, 1);
      pop_chk("R8 stored after flush");

      // R1 single-entry mode
      flush();
      fifo_en = 1'b0;
      send(8'h31, 0, 0);
      send(8'h32, 0, 0);
      chk("R1 single entry level", level, 1);
      chk("R1 single entry overrun", overrun, 1);
      pop_chk("R1 single entry keeps first");
      chk("R1 single entry empty", data_ready, 0);
      status_rd();
      fifo_en = 1'b1;
      flush();

      // R6 / R7 break
      parity_en = 1'b1;
      line_brk = 1'b1;
      ticks(BRKC);
      cyc(3);
      chk("R6 no break before limit", level, 0);
      ticks(1);
      cyc(2);
      chk("R6 break declared", level, 1);
      chk("R7 brk_flag", brk_flag, 1);
      chk("R7 frame_err", frame_err, 1);
      chk("R7 parity_err with parity", parity_err, 1);
      chk("R7 err_sum", err_sum, 1);
      chk("R7 data_ready", data_ready, 1);
      ticks(6);
      cyc(3);
      chk("R6 one break per event", level, 1);
      exp_q.push_back(8'h00);
      pop_chk("R7 break char zero");
      line_brk = 1'b0;
      status_rd();
      chk("R11 brk_flag cleared", brk_flag, 0);
      parity_en = 1'b0;
      cyc(1);
      line_brk = 1'b1;
      ticks(BRKC + 1);
      cyc(2);
      chk("R6 second break", level, 1);
      chk("R7 brk_flag second", brk_flag, 1);
      chk("R7 no parity without parity", parity_err, 0);
      exp_q.push_back(8'h00);
      pop_chk("R7 second break char");
      line_brk = 1'b0;
      status_rd();
      cyc(2);

      done = 1'b1;
      report();
   end

endmodule